// File: doc/BRIEF.md
# Two-Context Execution Mode Controller

This block sits beside a core that runs two hardware contexts at once and keeps track of which of them is running. From per-context halt pulses and interrupt pulses it keeps a halted flag for each context and reports a mode: both running (multi-task), only context 0 running, only context 1 running, or neither running. A context that executes a halt stops. An interrupt aimed at a stopped context starts it again.

In the same cycle the block also arbitrates one shared front-end structure, for example an instruction trace store or a microcode store. Only one context may use that structure in a cycle. Each context raises a request line, and the block returns a registered grant. A grant goes only to a context that is running. When both running contexts request, they take turns, so neither can hold the other off. When exactly one running context requests, it is served at once.

Top module: `ctx_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 2'b00 (multi-task), grant_o is 2'b00 and halted_o is 2'b00.
- R2: In multi-task mode, a halt pulse from only one context moves mode_o on the next cycle to the single-task code of the other context. The codes are 2'b01 when context 0 is the one running and 2'b10 when context 1 is the one running. The halting context's bit in halted_o is set in the same cycle.
- R3: In multi-task mode, halt pulses from both contexts in the same cycle move mode_o to 2'b11 (all halted), with halted_o at 2'b11.
- R4: In a single-task mode, an interrupt pulse to the halted context returns mode_o to 2'b00 on the next cycle. An interrupt pulse to a running context has no effect, and neither has a halt pulse from a halted context.
- R5: In the all-halted mode, an interrupt to a single context moves mode_o to that context's single-task code. Interrupts to both contexts in the same cycle move mode_o to 2'b00.
- R6: grant_o is registered, so it reflects the request of the previous cycle. It is always one-hot or zero.
- R7: When both contexts request and both stay running, the grant alternates between them on every cycle. The first such tie after reset goes to context 0 (grant_o = 2'b01).
- R8: When exactly one running context requests, that context receives the grant on the next cycle.
- R9: A context that is halted never receives a grant. This includes a context whose halt pulse arrives in the request cycle. In a single-task mode, only the running context can be granted.
- R10: If at least one running context that is not halting requests in a cycle, some grant is issued on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Per-context request for the shared structure |
| halt_i | input | 2 | Per-context one-cycle pulse: the context executed a halt |
| irq_i | input | 2 | Per-context one-cycle interrupt pulse |
| mode_o | output | 2 | Execution mode: 00 multi-task, 01 only context 0, 10 only context 1, 11 all halted |
| grant_o | output | 2 | Registered one-hot grant of the shared structure |
| halted_o | output | 2 | Per-context halted flag |

## Verification
The hardest situations to reach are the ones where a halt or an interrupt lands in the same cycle as a request tie. Examples are a context halting while both contexts request, and a wake from the all-halted mode while the other context's request is pending. In those cycles the arbiter has to use the halted state the mode logic is about to take on, not the state it holds now. A fixed vector sequence walks through every mode transition with requests held high, so that these collisions happen at known points. It is followed by a long run of pseudo-random pulses and requests, checked each cycle against a reference model in the bench, which reaches the rarer combinations such as both interrupts arriving in the all-halted mode.

// File: rtl/ctxm_pkg.sv
package ctxm_pkg;

   typedef enum logic [1:0] {
      MODE_MT   = 2'b00,
      MODE_ST0  = 2'b01,
      MODE_ST1  = 2'b10,
      MODE_IDLE = 2'b11
   } ctx_mode_e;

   // Halted vector bit i is context i; mode names the running set.
   function automatic ctx_mode_e mode_of(input logic [1:0] halted);
      case (halted)
         2'b00:   mode_of = MODE_MT;
         2'b10:   mode_of = MODE_ST0;
         2'b01:   mode_of = MODE_ST1;
         default: mode_of = MODE_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/ctxm_state.sv
module ctxm_state
   import ctxm_pkg::*;
#(
   parameter int NUM_CTX = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CTX-1:0] halt_i,
   input  logic [NUM_CTX-1:0] irq_i,
   output logic [NUM_CTX-1:0] halted_next,
   output logic [NUM_CTX-1:0] halted_q,
   output ctx_mode_e          mode_q
);

   // Per context: a halted one stays halted unless interrupted,
   // a running one halts only on its own halt pulse.
   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      always_comb begin
         if (halted_q[c]) halted_next[c] = ~irq_i[c];
         else             halted_next[c] = halt_i[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= '0;
         mode_q   <= MODE_MT;
      end else begin
         halted_q <= halted_next;
         mode_q   <= mode_of(halted_next);
      end
   end

endmodule

// File: rtl/ctxm_arb.sv
module ctxm_arb #(
   parameter int NUM_CTX   = 2,
   parameter int FIRST_CTX = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CTX-1:0] req_i,
   input  logic [NUM_CTX-1:0] run_next,
   output logic [NUM_CTX-1:0] grant_q
);

   localparam logic LAST_RST = (FIRST_CTX == 0) ? 1'b1 : 1'b0;

   logic [NUM_CTX-1:0] elig;
   logic [NUM_CTX-1:0] pick;
   logic               last_q;

   assign elig = req_i & run_next;

   always_comb begin
      if (&elig) pick = last_q ? 2'b01 : 2'b10;
      else       pick = elig;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '0;
         last_q  <= LAST_RST;
      end else begin
         grant_q <= pick;
         if (|pick) last_q <= pick[1];
      end
   end

endmodule

// File: rtl/ctx_mode_ctrl.sv
module ctx_mode_ctrl
   import ctxm_pkg::*;
#(
   parameter int NUM_CTX   = 2,
   parameter int FIRST_CTX = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CTX-1:0] req_i,
   input  logic [NUM_CTX-1:0] halt_i,
   input  logic [NUM_CTX-1:0] irq_i,
   output logic [1:0]         mode_o,
   output logic [NUM_CTX-1:0] grant_o,
   output logic [NUM_CTX-1:0] halted_o
);

   if (NUM_CTX != 2) begin : g_bad_ctx
      $error("ctx_mode_ctrl: NUM_CTX must be 2");
   end
   if (FIRST_CTX < 0 || FIRST_CTX >= NUM_CTX) begin : g_bad_first
      $error("ctx_mode_ctrl: FIRST_CTX out of range");
   end

   logic [NUM_CTX-1:0] halted_next;
   ctx_mode_e          mode_q;

   ctxm_state #(.NUM_CTX(NUM_CTX)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_i      (halt_i),
      .irq_i       (irq_i),
      .halted_next (halted_next),
      .halted_q    (halted_o),
      .mode_q      (mode_q)
   );

   ctxm_arb #(.NUM_CTX(NUM_CTX), .FIRST_CTX(FIRST_CTX)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .run_next (~halted_next),
      .grant_q  (grant_o)
   );

   assign mode_o = mode_q;

endmodule

// File: rtl/ctxm_checker.sv
module ctxm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] req_i,
   input logic [1:0] halt_i,
   input logic [1:0] irq_i,
   input logic [1:0] mode_o,
   input logic [1:0] grant_o,
   input logic [1:0] halted_o
);

   a_r6_grant_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   a_r9_no_grant_halted: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & halted_o) == 2'b00);

   a_r2_halt_to_st1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && halt_i == 2'b01) |=> (mode_o == 2'b10 && halted_o == 2'b01));

   a_r3_both_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && halt_i == 2'b11) |=> (mode_o == 2'b11));

   a_r4_wake_to_mt: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01 && irq_i[1] && !halt_i[0]) |=> (mode_o == 2'b00));

   a_r5_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b11 && irq_i == 2'b01) |=> (mode_o == 2'b01));

   a_r10_progress: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_i & ~halted_o & ~halt_i) != 2'b00) |=> (grant_o != 2'b00));

   a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o != 2'b00 && req_i == 2'b11 && halted_o == 2'b00 && halt_i == 2'b00)
      |=> (grant_o != $past(grant_o)));

   a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == 2'b01 && !halted_o[0] && !halt_i[0]) |=> (grant_o == 2'b01));

endmodule

bind ctx_mode_ctrl ctxm_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_i    (req_i),
   .halt_i   (halt_i),
   .irq_i    (irq_i),
   .mode_o   (mode_o),
   .grant_o  (grant_o),
   .halted_o (halted_o)
);

// File: tb/sim_ctx_mode_ctrl.sv
module sim_ctx_mode_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 22;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] req = '0, halt = '0, irq = '0;
   logic [1:0] mode, grant, halted;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   ctx_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .halt_i(halt), .irq_i(irq),
      .mode_o(mode), .grant_o(grant), .halted_o(halted)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // {req, halt, irq, exp_mode, exp_grant, exp_halted}
   localparam logic [11:0] VEC [NVEC] = '{
      12'b11_00_00_00_01_00, // R7 first tie to ctx0
      12'b11_00_00_00_10_00, // R7
      12'b11_00_00_00_01_00, // R7
      12'b10_00_00_00_10_00, // R8
      12'b10_00_00_00_10_00, // R8
      12'b11_00_00_00_01_00, // R7
      12'b11_01_00_10_10_01, // R2 R9
      12'b11_00_00_10_10_01, // R9
      12'b01_00_10_10_00_01, // R4 irq to running ignored
      12'b01_01_00_10_00_01, // R4 halt from halted ignored
      12'b11_00_01_00_01_00, // R4 wake to MT
      12'b00_10_00_01_00_10, // R2
      12'b11_00_00_01_01_10, // R9
      12'b11_01_00_11_00_11, // R9 all halted
      12'b11_00_00_11_00_11, // R9
      12'b11_00_10_10_10_01, // R5
      12'b11_10_00_11_00_11, // R9
      12'b00_00_11_00_00_00, // R5 both wake
      12'b11_11_00_11_00_11, // R3
      12'b11_00_01_01_01_10, // R5
      12'b11_00_10_00_10_00, // R4 R7
      12'b11_00_10_00_01_00  // R7 irq in MT ignored
   };

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(input logic [1:0] r, input logic [1:0] h, input logic [1:0] q);
      req = r; halt = h; irq = q;
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = '0; halt = '0; irq = '0;
      @(posedge clk); @(posedge clk); #1;
      check("R1 mode", mode, 2'b00);
      check("R1 grant", grant, 2'b00);
      check("R1 halted", halted, 2'b00);
      rst_n = 1'b1;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      logic [1:0] mh;
      logic       mlast;
      logic [15:0] lfsr;
      #1;
      do_reset();

      // vector table walk
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][11:10], VEC[i][9:8], VEC[i][7:6]);
         check($sformatf("R2-5 vec%0d mode", i), mode, VEC[i][5:4]);
         check($sformatf("R6-10 vec%0d grant", i), grant, VEC[i][3:2]);
         check($sformatf("R9 vec%0d halted", i), halted, VEC[i][1:0]);
      end

      // R1: reset from the all-halted mode, then the first tie goes to ctx0 (R7)
      step(2'b11, 2'b11, 2'b00);
      check("R3 pre-reset mode", mode, 2'b11);
      do_reset();
      step(2'b11, 2'b00, 2'b00);
      check("R7 tie after reset", grant, 2'b01);
      step(2'b01, 2'b00, 2'b00);
      check("R8 single ctx0", grant, 2'b01);

      // pseudo-random run against a reference model
      do_reset();
      mh = 2'b00; mlast = 1'b1; lfsr = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         logic [1:0] r, h, q, hn, el, g, m;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r = lfsr[1:0];
         h = lfsr[3:2] & lfsr[5:4] & lfsr[7:6];
         q = lfsr[9:8] & lfsr[11:10];
         for (int c = 0; c < 2; c++) hn[c] = mh[c] ? ~q[c] : h[c];
         el = r & ~hn;
         if (el == 2'b11) g = mlast ? 2'b01 : 2'b10;
         else             g = el;
         if (g != 2'b00) mlast = g[1];
         m = {hn[0], hn[1]};
         mh = hn;
         step(r, h, q);
         check("R10 random grant", grant, g);
         check("R2-5 random mode", mode, m);
         check("R9 random halted", halted, hn);
      end

      finish_up();
   end

endmodule